// File: doc/BRIEF.md
# Receiver-Paced Fast-to-Slow Word Transfer

This block carries a word of signals from a fast clock domain into a slow clock domain, for systems where the fast clock runs many times faster than the slow one. The slow domain does not synchronize the word at all. Instead it sets the pace of the transfer. On every rising edge of its own clock it inverts a single phase bit.

The fast domain passes that phase bit through a short synchronizer chain and compares the synchronized value with its value one fast cycle earlier. Each difference is a one-cycle load pulse. The pulse copies the current fast-domain word into a holding register, and the slow domain reads that register directly. A load happens only a few fast cycles after a slow edge, so the register is quiet for the rest of the slow period. The slow logic can therefore treat the word as a signal of its own domain.

The fast clock must be fast enough that a load finishes well before the next slow edge. With the default two-stage synchronizer, the slow period must exceed four fast periods. Each domain has its own synchronous active-low reset.

Top module: `fs_word_xfer`

## Requirements
- R1: While the fast reset is low, the output word is all zeros. While the slow reset is low, no load takes place, so the output word stays all zeros after the fast reset is released.
- R2: Each rising slow edge sampled with the slow reset high causes exactly one load in the fast domain. Slow edges sampled while the slow reset is low cause none.
- R3: With the default two synchronizer stages, the output word takes a new value at the third rising fast edge after the slow edge that triggered the load. The new value is the input word as sampled at that fast edge.
- R4: At every other fast edge, the output word keeps its previous value, whatever the input word does.
- R5: At each rising slow edge after the first one that followed the slow reset release, the output word equals the word loaded in response to the previous slow edge. This holds when the slow period is at least six fast periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; it clocks the synchronizer, the change detector and the holding register |
| rst_fast_n | input | 1 | Synchronous active-low reset for the fast domain |
| clk_slow | input | 1 | Slow clock; it clocks the phase bit |
| rst_slow_n | input | 1 | Synchronous active-low reset for the slow domain |
| src_data | input | WIDTH | Word from the fast domain that is to be transferred |
| xfer_data | output | WIDTH | Holding register; the slow domain reads it without a synchronizer |

## Verification
Suppose the synchronizer depth, the previous-value flop or the change detector is wrong. Then the output word moves one fast cycle early or late, captures a different input sample, or changes twice or never for a single slow edge. The bench compares the word against its model on every fast cycle, so such a fault shows within three fast cycles of the slow edge concerned. If the phase bit stops inverting, or the load fails to complete in time, the word held at the next slow edge is stale, and the slow-edge check catches it one slow period later.

// File: rtl/fs_xfer_pkg.sv
// Package: shared constants and helpers for the fast-to-slow word transfer.
// Assumes: the synchronizer depth is at least two.
package fs_xfer_pkg;

    localparam int unsigned DEFAULT_WIDTH       = 16;
    localparam int unsigned DEFAULT_SYNC_STAGES = 2;

    // Number of fast edges from a slow edge to the update of the holding register.
    function automatic int unsigned load_latency(input int unsigned stages);
        return stages + 1;
    endfunction

endpackage

// File: rtl/fs_phase_gen.sv
// Slow-domain phase generator: inverts one bit on every slow clock edge.
// Assumes: synchronous active-low reset; the bit is zero after reset.
module fs_phase_gen (
    input  logic clk_slow,
    input  logic rst_slow_n,
    output logic phase
);

    // Invert the phase bit on every slow edge outside reset.
    always_ff @(posedge clk_slow) begin
        if (!rst_slow_n) phase <= 1'b0;
        else             phase <= ~phase;
    end

    // R2: after a cycle out of reset, the phase bit differs from its previous value.
    a_r2_phase_inverts: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
        $past(rst_slow_n) |-> (phase != $past(phase)));

endmodule

// File: rtl/fs_phase_detect.sv
// Fast-domain synchronizer and change detector for the slow phase bit.
// Resynchronizes through SYNC_STAGES flops, keeps one previous value and
// raises a one-cycle pulse on every change.
// Assumes: the fast clock is several times faster than the slow clock.
module fs_phase_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_fast,
    input  logic rst_fast_n,
    input  logic phase_async,
    output logic change
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the asynchronous phase bit through the synchronizer chain.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk_fast) begin
                    if (!rst_fast_n) sync_q[0] <= 1'b0;
                    else             sync_q[0] <= phase_async;
                end
            end else begin : g_next
                always_ff @(posedge clk_fast) begin
                    if (!rst_fast_n) sync_q[s] <= 1'b0;
                    else             sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // Keep the synchronized value from one fast cycle earlier.
    always_ff @(posedge clk_fast) begin
        if (!rst_fast_n) prev_q <= 1'b0;
        else             prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Flag a change between the current and previous synchronized values.
    always_comb change = sync_q[SYNC_STAGES-1] ^ prev_q;

    // R3: a change pulse is a single fast cycle wide when the ratio holds.
    a_r3_pulse_single: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        change |=> !change);

endmodule

// File: rtl/fs_hold_reg.sv
// Fast-domain holding register: captures the input word on a load pulse and
// keeps it otherwise.
// Assumes: the load pulse is one fast cycle wide.
module fs_hold_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk_fast,
    input  logic             rst_fast_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // Capture the word on a load pulse; otherwise hold it.
    always_ff @(posedge clk_fast) begin
        if (!rst_fast_n) dout <= '0;
        else if (load)   dout <= din;
    end

endmodule

// File: rtl/fs_word_xfer.sv
// Top level: moves a word from a fast domain to a slow domain. The slow side
// sets the pace with a phase bit, and the fast side updates the holding
// register just after each slow edge.
// Assumes: the slow period exceeds SYNC_STAGES+2 fast periods; separate resets.
module fs_word_xfer
    import fs_xfer_pkg::*;
#(
    parameter int unsigned WIDTH       = DEFAULT_WIDTH,
    parameter int unsigned SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
    input  logic             clk_fast,
    input  logic             rst_fast_n,
    input  logic             clk_slow,
    input  logic             rst_slow_n,
    input  logic [WIDTH-1:0] src_data,
    output logic [WIDTH-1:0] xfer_data
);

    localparam int unsigned LATENCY = load_latency(SYNC_STAGES);

    logic phase;
    logic load;

    fs_phase_gen u_phase (
        .clk_slow   (clk_slow),
        .rst_slow_n (rst_slow_n),
        .phase      (phase)
    );

    fs_phase_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk_fast    (clk_fast),
        .rst_fast_n  (rst_fast_n),
        .phase_async (phase),
        .change      (load)
    );

    fs_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk_fast   (clk_fast),
        .rst_fast_n (rst_fast_n),
        .load       (load),
        .din        (src_data),
        .dout       (xfer_data)
    );

    // R4: the output word moves only in the cycle after a load pulse.
    a_r4_move_needs_load: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        ($past(rst_fast_n) && (xfer_data != $past(xfer_data))) |-> $past(load));

    // R1: the output word is zero in the first cycle after the fast reset is released.
    a_r1_zero_after_reset: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        $rose(rst_fast_n) |-> (xfer_data == '0));

    // R3: a loaded word is the input word from the load cycle.
    a_r3_load_takes_input: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        ($past(rst_fast_n) && $past(load)) |-> (xfer_data == $past(src_data)));

    // The latency is fixed by the synchronizer depth.
    initial begin
        a_r3_latency_floor: assert (LATENCY >= 3);
    end

endmodule

// File: tb/test_fs_word_xfer.sv
// Bench: a 50 MHz fast clock and a slow clock with a random period. The
// input words are random or directed patterns. The model counts fast edges
// from each slow edge.
module test_fs_word_xfer;

    localparam int unsigned W = 16;

    logic         clk_fast = 1'b0;
    logic         clk_slow = 1'b0;
    logic         rst_fast_n = 1'b0;
    logic         rst_slow_n = 1'b0;
    logic [W-1:0] src_data = '0;
    logic [W-1:0] xfer_data;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned mode     = 0;
    bit          done     = 1'b0;

    int unsigned  slow_cnt  = 0;
    int unsigned  seen_cnt  = 0;
    int unsigned  load_cnt  = 0;
    int unsigned  countdown = 0;
    logic [W-1:0] exp_q     = '0;
    bit           just_loaded = 1'b0;

    fs_word_xfer #(.WIDTH(W)) i_fs_word_xfer (
        .clk_fast   (clk_fast),
        .rst_fast_n (rst_fast_n),
        .clk_slow   (clk_slow),
        .rst_slow_n (rst_slow_n),
        .src_data   (src_data),
        .xfer_data  (xfer_data)
    );

    always #10 clk_fast = ~clk_fast;

    // Slow clock: edges at 3 ns past a 20 ns grid, half period of 3 to 6 fast periods.
    initial begin
        void'($urandom(32'h5EED_0042));
        #3;
        forever begin
            #(20 * (3 + ($urandom % 4)));
            clk_slow = ~clk_slow;
        end
    end

    function automatic logic [W-1:0] gen_word(input int unsigned m);
        case (m)
            1:       return '1;
            2:       return {(W/2){2'b10}};
            3:       return '0;
            default: return W'($urandom);
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: xfer_data=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Count the slow edges that the design should act on (R2).
    always @(posedge clk_slow) begin
        if (rst_slow_n) begin
            // R5 and R2: the previous edge's load is complete and unique.
            if (slow_cnt >= 1) begin
                check("R5", xfer_data, exp_q);
                n_checks++;
                if (load_cnt != slow_cnt) begin
                    n_fail++;
                    $display("FAIL R2: loads=%0d expected=%0d", load_cnt, slow_cnt);
                end
            end
            slow_cnt = slow_cnt + 1;
        end
    end

    // Model: the load takes effect at the third fast edge after a slow edge (R3).
    always @(posedge clk_fast) begin
        just_loaded = 1'b0;
        if (!rst_fast_n) begin
            exp_q = '0;
            countdown = 0;
            seen_cnt = slow_cnt;
        end else begin
            if (slow_cnt != seen_cnt) begin
                seen_cnt = slow_cnt;
                countdown = 3;
            end
            if (countdown > 0) begin
                countdown = countdown - 1;
                if (countdown == 0) begin
                    exp_q = src_data;
                    load_cnt = load_cnt + 1;
                    just_loaded = 1'b1;
                end
            end
        end
    end

    // Drive new words and compare away from the active edge.
    always @(negedge clk_fast) begin
        if (!done) begin
            if (!rst_fast_n || !rst_slow_n)   check("R1", xfer_data, '0);
            else if (just_loaded)             check("R3", xfer_data, exp_q);
            else                              check("R4", xfer_data, exp_q);
            src_data = gen_word(mode);
        end
    end

    initial begin
        // R1: both resets held, then only the fast side released.
        #100 rst_fast_n = 1'b1;
        #900 rst_slow_n = 1'b1;
        // Random words, then the directed patterns.
        #40000;
        mode = 1; #8000;
        mode = 2; #8000;
        mode = 3; #8000;
        mode = 0; #20000;
        done = 1'b1;
        #20;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: counts as a failed check.
    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: expired before completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule